// File: doc/BRIEF.md
# SPI Master with Ordered Command and Data Queue

This block is a serial peripheral master whose transmit side is fed through one ordered queue that takes two kinds of entries. A data write carries one frame's payload. A command write changes the frame length, picks which of four chip-select lines to drive, and sets whether that select stays low across frame boundaries. Because both kinds share the queue, a settings change lands exactly between the frames written before and after it. Software can therefore queue several configurations ahead without waiting for the shift engine to go idle.

Frames are shifted most significant bit first in clock mode 0: SCK rests low, input is sampled on the rising edge and output changes on the falling edge. Every data frame yields one received word, right-aligned, in a small receive queue that is read first-word-fall-through. Only one chip select is ever low. It is named by an index rather than a mask.

Top module: `spi_cmdq_master`

## Requirements
- R1: A data frame puts its low N bits on `mosi` most significant bit first, where N is the current frame size (1 to 32). During the frame `sck` gives N pulses, input is sampled on the rising edge, and `sck` is low whenever no frame is shifting.
- R2: A command word encodes the frame size minus one in bits [4:0], the chip-select index in bits [25:24] and the hold-select flag in bit 21. After reset the size is 8, the index is 0 and the hold flag is clear.
- R3: Entries leave the queue in the order they were written. A command applies to every data frame written after it and to none written before it.
- R4: While a frame shifts, exactly the `cs_n` line named by the current index is low. No more than one `cs_n` line is ever low.
- R5: With the hold flag clear, `cs_n` returns high after each frame. With it set, the select stays low between frames until a command clears the flag or names another index.
- R6: Each data frame pushes one word into a 4-entry receive queue. The received bits are right-aligned and all bits above them are zero. `rx_valid` shows a word is present and `rx_rd` removes the head.
- R7: While the receive queue is full, no new data frame starts. Shifting resumes once a word is read.
- R8: The transmit queue holds 8 entries and raises `q_full` when it has 8. A write while full is dropped and sets `err`, which stays set until reset.
- R9: If `cmd_wr` and `data_wr` are asserted in the same cycle, the command is queued, the data word is dropped, and `err` is set.
- R10: After reset all `cs_n` lines are high, `sck` is low, and `q_full`, `err` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_wr | input | 1 | Queue a data word |
| data_in | input | 32 | Data payload, low bits used |
| cmd_wr | input | 1 | Queue a command word |
| cmd_in | input | 32 | Command payload |
| q_full | output | 1 | Transmit queue holds 8 entries |
| err | output | 1 | Sticky dropped-write flag |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| rx_rd | input | 1 | Pop the receive head |
| rx_data | output | 32 | Receive head word |
| rx_valid | output | 1 | Receive queue not empty |

## Verification
The two writes that can collide in one clock are a command and a data word, and the queue accepts only one entry per cycle. The bench raises both strobes on the same edge. It then expects the error flag to be set and expects no frame for the lost word. It also expects the next frame to use the width and select carried by the command that got through. A serial monitor loops `mosi` back to `miso` and compares every frame's bit count, select line and value against a scoreboard filled by the driver tasks.

// File: rtl/spi_cmdq_pkg.sv
package spi_cmdq_pkg;
    localparam int WORD_W     = 32;
    localparam int NUM_CS     = 4;
    localparam int CS_IDX_W   = 2;
    localparam int SIZE_W     = 5;
    localparam int CMD_SIZE_LSB = 0;
    localparam int CMD_HOLD_BIT = 21;
    localparam int CMD_CS_LSB   = 24;

    typedef struct packed {
        logic              is_cmd;
        logic [WORD_W-1:0] payload;
    } qentry_t;

    typedef enum logic [0:0] {ST_IDLE, ST_SHIFT} eng_state_t;
endpackage

// File: rtl/spi_cmdq_fifo.sv
module spi_cmdq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_push, do_pop;

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign rdata = q.mem[q.rp];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.mem[q.wp] = wdata;
            d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
endmodule

// File: rtl/spi_cmdq_engine.sv
module spi_cmdq_engine
    import spi_cmdq_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_valid,
    input  qentry_t            tx_entry,
    output logic               tx_pop,
    input  logic               rx_full,
    output logic               rx_push,
    output logic [WORD_W-1:0]  rx_word,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic [NUM_CS-1:0]  cs_n
);
    localparam int TW = $clog2(HALF + 1);

    typedef struct packed {
        eng_state_t          st;
        logic                sck;
        logic [TW-1:0]       tmr;
        logic [SIZE_W-1:0]   left;
        logic [WORD_W-1:0]   sh;
        logic [WORD_W-1:0]   rx;
        logic [SIZE_W-1:0]   size;
        logic [CS_IDX_W-1:0] idx;
        logic                hold;
        logic                cs_act;
    } eng_t;

    eng_t q, d;
    logic [SIZE_W-1:0]   n_size;
    logic [CS_IDX_W-1:0] n_idx;
    logic                n_hold;

    assign n_size = tx_entry.payload[CMD_SIZE_LSB +: SIZE_W];
    assign n_idx  = tx_entry.payload[CMD_CS_LSB +: CS_IDX_W];
    assign n_hold = tx_entry.payload[CMD_HOLD_BIT];

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (tx_valid) begin
                    if (tx_entry.is_cmd) begin
                        tx_pop   = 1'b1;
                        d.size   = n_size;
                        d.idx    = n_idx;
                        d.hold   = n_hold;
                        d.cs_act = q.cs_act && n_hold && (n_idx == q.idx);
                    end else if (!rx_full) begin
                        tx_pop   = 1'b1;
                        d.sh     = tx_entry.payload << (5'd31 - q.size);
                        d.rx     = '0;
                        d.left   = q.size;
                        d.tmr    = '0;
                        d.sck    = 1'b0;
                        d.cs_act = 1'b1;
                        d.st     = ST_SHIFT;
                    end
                end
            end
            default: begin
                if (q.tmr == TW'(HALF - 1)) begin
                    d.tmr = '0;
                    d.sck = !q.sck;
                    if (!q.sck) begin
                        d.rx = {q.rx[WORD_W-2:0], miso};
                    end else if (q.left == '0) begin
                        d.st     = ST_IDLE;
                        rx_push  = 1'b1;
                        d.cs_act = q.hold;
                    end else begin
                        d.left = q.left - 1'b1;
                        d.sh   = q.sh << 1;
                    end
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.size <= SIZE_W'(7);
        end else begin
            q <= d;
        end
    end

    assign sck     = q.sck;
    assign mosi    = q.sh[WORD_W-1];
    assign rx_word = q.rx;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(q.cs_act && (q.idx == CS_IDX_W'(i)));
    end

    assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.sck);
    assert_cs_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && $past(q.st) == ST_SHIFT) |-> (q.cs_act && $stable(q.idx)));
    assert_no_rx_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
    assert_cmd_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_entry.is_cmd) |-> (q.st == ST_IDLE));
endmodule

// File: rtl/spi_cmdq_master.sv
module spi_cmdq_master
    import spi_cmdq_pkg::*;
#(
    parameter int QDEPTH  = 8,
    parameter int RXDEPTH = 4,
    parameter int HALF    = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        data_wr,
    input  logic [31:0] data_in,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_in,
    output logic        q_full,
    output logic        err,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  cs_n,
    input  logic        rx_rd,
    output logic [31:0] rx_data,
    output logic        rx_valid
);
    typedef struct packed { logic err; } top_t;
    top_t q, d;

    qentry_t              wr_entry, tx_head;
    logic                 wr_any, tx_empty, tx_pop;
    logic                 rx_push, rx_full, rx_empty;
    logic [WORD_W-1:0]    rx_word;

    assign wr_any   = cmd_wr || data_wr;
    assign wr_entry = cmd_wr ? qentry_t'({1'b1, cmd_in}) : qentry_t'({1'b0, data_in});

    always_comb begin
        d = q;
        if ((wr_any && q_full) || (cmd_wr && data_wr)) d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign err = q.err;

    spi_cmdq_fifo #(.W($bits(qentry_t)), .DEPTH(QDEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_any), .wdata(wr_entry),
        .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(q_full));

    spi_cmdq_engine #(.HALF(HALF)) u_eng (
        .clk(clk), .rst_n(rst_n), .tx_valid(!tx_empty), .tx_entry(tx_head),
        .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
        .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n));

    spi_cmdq_fifo #(.W(WORD_W), .DEPTH(RXDEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(rx_rd), .rdata(rx_data), .empty(rx_empty), .full(rx_full));

    assign rx_valid = !rx_empty;

    assert_one_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    assert_dual_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && data_wr) |=> err);
endmodule

// File: tb/tb_spi_cmdq_master.sv
module tb_spi_cmdq_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        data_wr = 1'b0, cmd_wr = 1'b0, rx_rd = 1'b0;
    logic [31:0] data_in = '0, cmd_in = '0;
    logic        q_full, err, sck, mosi, rx_valid;
    logic [3:0]  cs_n;
    logic [31:0] rx_data;

    int checks = 0, errors = 0, cyc = 0;
    int frames_seen = 0, deass = 0, bitn = 0;

    typedef struct { int len; logic [3:0] csn; logic [31:0] data; } frame_t;
    frame_t      exp_q[$];
    logic [31:0] exp_rx[$];
    frame_t      cur;
    logic [31:0] acc;

    int   m_size = 8, m_idx = 0;

    always #2 clk = !clk;

    spi_cmdq_master dut (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
        .cmd_wr(cmd_wr), .cmd_in(cmd_in), .q_full(q_full), .err(err),
        .sck(sck), .mosi(mosi), .miso(mosi), .cs_n(cs_n),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] mask_of(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    endfunction

    // Serial monitor: pops the scoreboard on the first bit of each frame.
    always @(posedge sck) begin
        if (bitn == 0) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3 unexpected frame", 32'(frames_seen), 0);
                cur = '{8, 4'hF, 32'h0};
            end else begin
                cur = exp_q.pop_front();
            end
            acc = '0;
            chk(cs_n == cur.csn, "R4 select line", 32'(cs_n), 32'(cur.csn));
        end
        acc = {acc[30:0], mosi};
        bitn++;
        if (bitn == cur.len) begin
            chk(acc == (cur.data & mask_of(cur.len)), "R1 frame bits", acc, cur.data & mask_of(cur.len));
            frames_seen++;
            bitn = 0;
        end
    end

    wire all_hi = &cs_n;
    always @(posedge all_hi) deass++;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send_cmd(input int size, input int idx, input bit hold);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_in = '0;
        cmd_in[4:0]   = 5'(size - 1);
        cmd_in[25:24] = 2'(idx);
        cmd_in[21]    = hold;
        @(negedge clk);
        cmd_wr = 1'b0;
        m_size = size;
        m_idx  = idx;
    endtask

    task automatic send_data(input logic [31:0] v, input bit accepted);
        @(negedge clk);
        data_wr = 1'b1;
        data_in = v;
        @(negedge clk);
        data_wr = 1'b0;
        if (accepted) begin
            exp_q.push_back('{m_size, ~(4'b1 << m_idx), v});
            exp_rx.push_back(v & mask_of(m_size));
        end
    endtask

    task automatic rd_all(input string tag);
        while (exp_rx.size() > 0) begin
            @(negedge clk);
            if (rx_valid) begin
                logic [31:0] e;
                e = exp_rx.pop_front();
                chk(rx_data == e, tag, rx_data, e);
                rx_rd = 1'b1;
                @(negedge clk);
                rx_rd = 1'b0;
            end
        end
    endtask

    task automatic wait_frames(input int target);
        while (frames_seen < target) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_size = 8;
        m_idx  = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int base, d0;
        do_reset();
        // R10: reset values at the ports
        chk(cs_n == 4'hF, "R10 cs_n", 32'(cs_n), 32'hF);
        chk(!sck, "R10 sck", 32'(sck), 0);
        chk(!q_full && !err, "R10 q_full/err", {30'b0, q_full, err}, 0);
        chk(!rx_valid, "R10 rx_valid", 32'(rx_valid), 0);

        // R2: reset settings are 8 bits on select 0; R5 deassert per frame
        d0 = deass;
        send_data(32'h1234_56A5, 1);
        send_data(32'h0000_003C, 1);
        wait_frames(2);
        chk(deass - d0 == 2, "R5 release per frame", 32'(deass - d0), 2);
        chk(!sck, "R1 sck idle low", 32'(sck), 0);
        rd_all("R6 rx default size");

        // R3: settings interleaved with data, queued back to back
        base = frames_seen;
        send_cmd(32, 2, 0);
        send_data(32'hDEAD_BEEF, 1);
        send_cmd(1, 1, 0);
        send_data(32'h0000_0003, 1);
        send_cmd(12, 3, 0);
        send_data(32'h0000_ABC5, 1);
        wait_frames(base + 3);
        rd_all("R6 rx mixed sizes R3");

        // R5: hold flag keeps select low between frames
        base = frames_seen;
        d0 = deass;
        send_cmd(16, 1, 1);
        send_data(32'hFFFF_8001, 1);
        send_data(32'h0000_7FFE, 1);
        send_cmd(16, 1, 0);
        send_data(32'h0000_1111, 1);
        wait_frames(base + 3);
        chk(deass - d0 == 2, "R5 hold then release", 32'(deass - d0), 2);
        rd_all("R6 rx upper zero");

        // R7: receive queue full stalls the next frame
        send_cmd(8, 0, 0);
        base = frames_seen;
        for (int i = 0; i < 5; i++) send_data(32'(8'h10 + i), 1);
        while (frames_seen < base + 4) @(negedge clk);
        repeat (200) @(negedge clk);
        chk(frames_seen == base + 4, "R7 stall while full", 32'(frames_seen - base), 4);
        chk(rx_valid, "R7 words held", 32'(rx_valid), 1);
        rd_all("R7 rx after stall");
        wait_frames(base + 5);
        chk(frames_seen == base + 5, "R7 resume", 32'(frames_seen - base), 5);

        // R8: fill queue while the engine is stalled
        base = frames_seen;
        for (int i = 0; i < 4; i++) send_data(32'(8'h40 + i), 1);
        wait_frames(base + 4);
        for (int i = 0; i < 8; i++) send_data(32'(8'h80 + i), 1);
        chk(q_full, "R8 full flag", 32'(q_full), 1);
        chk(!err, "R8 no error yet", 32'(err), 0);
        send_data(32'h0000_00EE, 0);
        chk(err, "R8 dropped write sets err", 32'(err), 1);
        rd_all("R8 rx after overflow");
        wait_frames(base + 12);
        chk(frames_seen == base + 12, "R8 dropped word never sent", 32'(frames_seen - base), 12);
        chk(err && !q_full, "R8 err sticky", {30'b0, err, q_full}, 32'h2);

        // R9: command and data in the same cycle
        do_reset();
        chk(!err, "R10 err cleared", 32'(err), 0);
        base = frames_seen;
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_in = '0;
        cmd_in[4:0] = 5'd3;
        cmd_in[25:24] = 2'd3;
        data_wr = 1'b1;
        data_in = 32'h0000_00FF;
        @(negedge clk);
        cmd_wr = 1'b0;
        data_wr = 1'b0;
        m_size = 4;
        m_idx = 3;
        chk(err, "R9 err on dual write", 32'(err), 1);
        repeat (100) @(negedge clk);
        chk(frames_seen == base, "R9 data dropped", 32'(frames_seen - base), 0);
        send_data(32'h0000_0009, 1);
        wait_frames(base + 1);
        rd_all("R9 command applied");
        chk(exp_q.size() == 0, "R3 all frames seen", 32'(exp_q.size()), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule